// File: doc/BRIEF.md
# Scatter-Gather DMA Engine

This block moves data between a SCSI-side data port and a 32-bit system memory bus. Software programs it through four registers behind a small write port: an 8-bit control/status register, a direct buffer address, a direct byte count and a table base address. The engine starts on the rising edge of its enable bit. In direct mode it moves one buffer described by the direct address and count registers. In table mode it walks a list of buffer descriptors held in memory.

Data moves one 32-bit word per cycle while four or more bytes remain. The last one to three bytes go as single-byte cycles. Faults stop the engine at once, and each fault has its own sticky status bit. Bus errors are reported separately for descriptor fetches and for data cycles. A descriptor fetched from memory that does not answer as a 32-bit port is also flagged, and so is a data handshake that reports an 8-bit port. A done bit marks every stop. All status bits clear only when software drops enable.

Memory and the SCSI side are both plain request/acknowledge ports. A request stays high until the matching acknowledge (or bus error) is seen on a rising clock edge.

Top module: `sgdma_engine`

## Requirements
- R1: After reset the control/status image reads 0x00 and neither the memory nor the SCSI request is asserted.
- R2: While enable (bit 0) is 0 the engine issues no requests and status bits 7..3 read 0. Writing enable to 0 clears any status that was set.
- R3: With bit 1 at 0 the engine moves the buffer given by the direct address and direct count registers. It uses word cycles (`mem_word`=1, address advances by 4) while the remaining count is at least 4, then byte cycles (address advances by 1). It sets done (bit 7) once the count is exactly 0. A count of 0 sets done with no bus cycle.
- R4: With bit 2 at 0 each chunk is first taken from the SCSI port and then written to memory (`mem_we`=1). With bit 2 at 1 each chunk is first read from memory and then sent to the SCSI port. A single byte travels in data bits 7:0.
- R5: With bit 1 at 1 the engine reads 8-byte descriptors starting at the table base: the buffer address at offset 0, then a word at offset 4 whose bits 23:0 hold the byte count and whose bit 31 marks the last descriptor. Descriptors with a zero count are skipped. Done is set after the last descriptor.
- R6: A bus error on a descriptor fetch sets bits 3 and 7 and ends all bus activity.
- R7: A bus error on a data cycle sets bits 4 and 7 and ends all bus activity.
- R8: A descriptor fetch acknowledged without the 32-bit port indication sets bits 5 and 7 and ends all bus activity.
- R9: A data cycle acknowledged with the 8-bit port indication sets bits 6 and 7 and ends all bus activity.
- R10: Status bits stay set while enable stays 1. Writing enable to 1 again while it is already 1 starts nothing.
- R11: While a transfer is running, writes to the mode and direction bits and to the address, count and table base registers have no effect. Enable stays writable.
- R12: `reg_sel` selects 0 = control/status, 1 = direct address, 2 = direct count, 3 = table base. Bits 7..3 of the control/status register are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| csr_o | output | 8 | Control/status image |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_word | output | 1 | Word cycle (1) or byte cycle (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory cycle acknowledge |
| mem_berr | input | 1 | Memory bus error |
| mem_port32 | input | 1 | Responding memory is a 32-bit port |
| mem_port8 | input | 1 | Responding memory is an 8-bit port |
| scsi_req | output | 1 | SCSI-side transfer request |
| scsi_word | output | 1 | SCSI transfer of 4 bytes (1) or 1 byte (0) |
| scsi_wdata | output | 32 | Data sent to the SCSI side |
| scsi_rdata | input | 32 | Data received from the SCSI side |
| scsi_ack | input | 1 | SCSI-side acknowledge |

## Verification
Direct transfers are run in both directions with odd and unaligned counts, which separates the word phase from the byte tail. A zero count shows that done is reached without any cycle. Table walks mix a zero-count descriptor with short and long ones, which tests skipping, the 8-byte pointer step and the last-descriptor stop. Faults are injected on particular bus cycles so that descriptor faults can be told apart from data faults and each status bit from its neighbours. A transfer that software pokes while busy, then restarts without reprogramming, shows that locked registers really kept their old values.

// File: rtl/sgdma_pkg.sv
`timescale 1ns/1ps
package sgdma_pkg;
    localparam int DW          = 32;
    localparam int ENTRY_BYTES = 8;
    localparam int LAST_BIT    = 31;
    localparam int STW         = 5;

    // index into the five status bits (register bits 3..7)
    localparam int STB_TBLBE  = 0;
    localparam int STB_DATBE  = 1;
    localparam int STB_TBLW   = 2;
    localparam int STB_NARROW = 3;
    localparam int STB_DONE   = 4;

    localparam logic [1:0] SEL_CSR   = 2'd0;
    localparam logic [1:0] SEL_DADDR = 2'd1;
    localparam logic [1:0] SEL_DCNT  = 2'd2;
    localparam logic [1:0] SEL_TBASE = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH_A, ST_FETCH_C, ST_CHECK, ST_SCSI, ST_MEM, ST_HALT
    } sg_state_e;
endpackage

// File: rtl/sgdma_regs.sv
`timescale 1ns/1ps
module sgdma_regs
    import sgdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    input  logic          busy,
    output logic          en,
    output logic          tmode,
    output logic          dir,
    output logic          start,
    output logic [AW-1:0] dir_addr,
    output logic [CW-1:0] dir_cnt,
    output logic [AW-1:0] tbl_addr
);
    typedef struct packed {
        logic          en;
        logic          en_prev;
        logic          tmode;
        logic          dir;
        logic [AW-1:0] daddr;
        logic [CW-1:0] dcnt;
        logic [AW-1:0] tbase;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d         = q;
        d.en_prev = q.en;
        if (reg_we) begin
            unique case (reg_sel)
                SEL_CSR: begin
                    d.en = reg_wdata[0];
                    if (!busy) begin
                        d.tmode = reg_wdata[1];
                        d.dir   = reg_wdata[2];
                    end
                end
                SEL_DADDR: if (!busy) d.daddr = reg_wdata;
                SEL_DCNT:  if (!busy) d.dcnt  = reg_wdata[CW-1:0];
                default:   if (!busy) d.tbase = reg_wdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en       = q.en;
    assign tmode    = q.tmode;
    assign dir      = q.dir;
    assign start    = q.en & ~q.en_prev;
    assign dir_addr = q.daddr;
    assign dir_cnt  = q.dcnt;
    assign tbl_addr = q.tbase;

    AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_sel == SEL_DADDR) |=> $stable(q.daddr)); // R11
    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_sel == SEL_CSR) |=> ($stable(q.tmode) && $stable(q.dir))); // R11
endmodule

// File: rtl/sgdma_core.sv
`timescale 1ns/1ps
module sgdma_core
    import sgdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tmode,
    input  logic          dir,
    input  logic          start,
    input  logic [AW-1:0] dir_addr,
    input  logic [CW-1:0] dir_cnt,
    input  logic [AW-1:0] tbl_addr,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_word,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_berr,
    input  logic          mem_port32,
    input  logic          mem_port8,
    output logic          scsi_req,
    output logic          scsi_word,
    output logic [DW-1:0] scsi_wdata,
    input  logic [DW-1:0] scsi_rdata,
    input  logic          scsi_ack,
    output logic [STW-1:0] stat,
    output logic          busy
);
    typedef struct packed {
        sg_state_e     st;
        logic [AW-1:0] addr;
        logic [AW-1:0] ptr;
        logic [CW-1:0] cnt;
        logic          last;
        logic [DW-1:0] hold;
        logic [STW-1:0] stat;
    } core_t;

    core_t q, d;
    logic          big;
    logic [AW-1:0] astep;
    logic [CW-1:0] cstep;

    assign big   = (q.cnt >= CW'(4));
    assign astep = big ? AW'(4) : AW'(1);
    assign cstep = big ? CW'(4) : CW'(1);

    always_comb begin
        d = q;
        if (!en) begin
            d.st   = ST_IDLE;
            d.stat = '0;
        end else begin
            unique case (q.st)
                ST_IDLE: if (start) begin
                    d.stat = '0;
                    if (tmode) begin
                        d.ptr = tbl_addr;
                        d.st  = ST_FETCH_A;
                    end else begin
                        d.addr = dir_addr;
                        d.cnt  = dir_cnt;
                        d.last = 1'b1;
                        d.st   = ST_CHECK;
                    end
                end
                ST_FETCH_A, ST_FETCH_C: begin
                    if (mem_berr) begin
                        d.stat[STB_TBLBE] = 1'b1;
                        d.stat[STB_DONE]  = 1'b1;
                        d.st              = ST_HALT;
                    end else if (mem_ack) begin
                        if (!mem_port32) begin
                            d.stat[STB_TBLW] = 1'b1;
                            d.stat[STB_DONE] = 1'b1;
                            d.st             = ST_HALT;
                        end else if (q.st == ST_FETCH_A) begin
                            d.addr = mem_rdata[AW-1:0];
                            d.st   = ST_FETCH_C;
                        end else begin
                            d.cnt  = mem_rdata[CW-1:0];
                            d.last = mem_rdata[LAST_BIT];
                            d.ptr  = q.ptr + AW'(ENTRY_BYTES);
                            d.st   = ST_CHECK;
                        end
                    end
                end
                ST_CHECK: begin
                    if (q.cnt == '0) begin
                        if (tmode && !q.last) begin
                            d.st = ST_FETCH_A;
                        end else begin
                            d.stat[STB_DONE] = 1'b1;
                            d.st             = ST_HALT;
                        end
                    end else begin
                        d.st = dir ? ST_MEM : ST_SCSI;
                    end
                end
                ST_SCSI: if (scsi_ack) begin
                    if (!dir) begin
                        d.hold = scsi_rdata;
                        d.st   = ST_MEM;
                    end else begin
                        d.addr = q.addr + astep;
                        d.cnt  = q.cnt - cstep;
                        d.st   = ST_CHECK;
                    end
                end
                ST_MEM: begin
                    if (mem_berr) begin
                        d.stat[STB_DATBE] = 1'b1;
                        d.stat[STB_DONE]  = 1'b1;
                        d.st              = ST_HALT;
                    end else if (mem_ack) begin
                        if (mem_port8) begin
                            d.stat[STB_NARROW] = 1'b1;
                            d.stat[STB_DONE]   = 1'b1;
                            d.st               = ST_HALT;
                        end else if (dir) begin
                            d.hold = mem_rdata;
                            d.st   = ST_SCSI;
                        end else begin
                            d.addr = q.addr + astep;
                            d.cnt  = q.cnt - cstep;
                            d.st   = ST_CHECK;
                        end
                    end
                end
                ST_HALT: ;
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        mem_req = en && (q.st == ST_FETCH_A || q.st == ST_FETCH_C || q.st == ST_MEM);
        unique case (q.st)
            ST_FETCH_A: mem_addr = q.ptr;
            ST_FETCH_C: mem_addr = q.ptr + AW'(4);
            default:    mem_addr = q.addr;
        endcase
    end

    assign mem_we     = (q.st == ST_MEM) && !dir;
    assign mem_word   = (q.st == ST_MEM) ? big : 1'b1;
    assign mem_wdata  = q.hold;
    assign scsi_req   = en && (q.st == ST_SCSI);
    assign scsi_word  = big;
    assign scsi_wdata = q.hold;
    assign stat       = q.stat;
    assign busy       = (q.st != ST_IDLE) && (q.st != ST_HALT);

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        q.stat[STB_DONE] |-> (!mem_req && !scsi_req)); // R6
    AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q.stat[STB_NARROW:STB_TBLBE])); // R7
    AST_CLEAN_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.stat[STB_DONE]) && q.stat[STB_NARROW:STB_TBLBE] == '0) |-> (q.cnt == '0)); // R3
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (q.stat == '0)); // R2
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(q.stat[STB_DONE])) |-> q.stat[STB_DONE]); // R10
endmodule

// File: rtl/sgdma_engine.sv
`timescale 1ns/1ps
module sgdma_engine
    import sgdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic [7:0]    csr_o,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_word,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_berr,
    input  logic          mem_port32,
    input  logic          mem_port8,
    output logic          scsi_req,
    output logic          scsi_word,
    output logic [DW-1:0] scsi_wdata,
    input  logic [DW-1:0] scsi_rdata,
    input  logic          scsi_ack
);
    logic          en, tmode, dir, start, busy;
    logic [AW-1:0] dir_addr, tbl_addr;
    logic [CW-1:0] dir_cnt;
    logic [STW-1:0] stat;

    sgdma_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .busy(busy), .en(en), .tmode(tmode), .dir(dir),
        .start(start), .dir_addr(dir_addr), .dir_cnt(dir_cnt), .tbl_addr(tbl_addr)
    );

    sgdma_core #(.AW(AW), .CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en), .tmode(tmode), .dir(dir), .start(start),
        .dir_addr(dir_addr), .dir_cnt(dir_cnt), .tbl_addr(tbl_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_berr(mem_berr), .mem_port32(mem_port32), .mem_port8(mem_port8),
        .scsi_req(scsi_req), .scsi_word(scsi_word), .scsi_wdata(scsi_wdata),
        .scsi_rdata(scsi_rdata), .scsi_ack(scsi_ack), .stat(stat), .busy(busy)
    );

    assign csr_o = {(en ? stat : '0), dir, tmode, en};

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && scsi_req)); // R4
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> (!mem_req && !scsi_req)); // R2
endmodule

// File: tb/sgdma_engine_tb.sv
`timescale 1ns/1ps
module sgdma_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [7:0]  csr_o;
    logic        mem_req, mem_we, mem_word;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 32'h0;
    logic        mem_ack = 1'b0, mem_berr = 1'b0, mem_port32 = 1'b1, mem_port8 = 1'b0;
    logic        scsi_req, scsi_word;
    logic [31:0] scsi_wdata;
    logic [31:0] scsi_rdata = 32'h0;
    logic        scsi_ack = 1'b0;

    always #2 clk = ~clk;

    sgdma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .csr_o(csr_o), .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_berr(mem_berr), .mem_port32(mem_port32),
        .mem_port8(mem_port8), .scsi_req(scsi_req), .scsi_word(scsi_word),
        .scsi_wdata(scsi_wdata), .scsi_rdata(scsi_rdata), .scsi_ack(scsi_ack)
    );

    typedef struct { logic [31:0] a; bit w; bit we; bit f; } op_t;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    op_t exp_q[$];
    int unsigned seg_a[$], seg_c[$];
    byte unsigned mem[int unsigned];
    byte unsigned src_q[$], src_exp[$], sink_q[$];
    int op_idx = 0, err_at = -1, err_kind = 0;
    logic [7:0] exp_hi;
    int unsigned e_addr[4], e_cnt[4];
    bit e_last[4];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic byte unsigned rd8(int unsigned a);
        return mem.exists(a) ? mem[a] : 8'(a * 7 + 3);
    endfunction

    task automatic put_word(int unsigned a, logic [31:0] v);
        for (int b = 0; b < 4; b++) mem[a + b] = v[8*b +: 8];
    endtask

    task automatic wr(logic [1:0] s, logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // reference model of the bus cycle stream
    function automatic void add_data(int unsigned a, int unsigned c, bit dr);
        while (c > 0) begin
            if (c >= 4) begin
                exp_q.push_back('{a: a, w: 1'b1, we: !dr, f: 1'b0});
                a += 4; c -= 4;
            end else begin
                exp_q.push_back('{a: a, w: 1'b0, we: !dr, f: 1'b0});
                a += 1; c -= 1;
            end
        end
    endfunction

    function automatic void build(bit tm, bit dr, int unsigned da, int unsigned dc,
                                  int unsigned tb, int ne);
        op_t e;
        int unsigned ptr;
        ptr = tb;
        exp_q.delete(); seg_a.delete(); seg_c.delete();
        if (!tm) begin
            seg_a.push_back(da); seg_c.push_back(dc); add_data(da, dc, dr);
        end else begin
            for (int i = 0; i < ne; i++) begin
                exp_q.push_back('{a: ptr, w: 1'b1, we: 1'b0, f: 1'b1});
                exp_q.push_back('{a: ptr + 4, w: 1'b1, we: 1'b0, f: 1'b1});
                seg_a.push_back(e_addr[i]); seg_c.push_back(e_cnt[i]);
                add_data(e_addr[i], e_cnt[i], dr);
                if (e_last[i]) break;
                ptr += 8;
            end
        end
        exp_hi = 8'h80;
        if (err_at >= 0 && err_at < exp_q.size()) begin
            e = exp_q[err_at];
            if (e.f && err_kind == 1)       exp_hi |= 8'h08;
            else if (!e.f && err_kind == 1) exp_hi |= 8'h10;
            else if (e.f && err_kind == 2)  exp_hi |= 8'h20;
            else if (!e.f && err_kind == 3) exp_hi |= 8'h40;
            while (exp_q.size() > err_at + 1) void'(exp_q.pop_back());
        end
    endfunction

    // memory responder: compares every handshake against the model
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack || mem_berr) begin
                mem_ack = 1'b0; mem_berr = 1'b0; mem_port32 = 1'b1; mem_port8 = 1'b0;
            end else if (mem_req) begin
                int kind;
                op_t e;
                kind = (op_idx == err_at) ? err_kind : 0;
                if (exp_q.size() == 0) begin
                    chk("R3", "unexpected memory cycle at", mem_addr, 32'hffff_ffff);
                end else begin
                    e = exp_q.pop_front();
                    chk(e.f ? "R5" : "R3", "memory cycle address", mem_addr, e.a);
                    chk("R3", "memory cycle word flag", 32'(mem_word), 32'(e.w));
                    chk("R4", "memory cycle write flag", 32'(mem_we), 32'(e.we));
                end
                if (mem_we) begin
                    if (mem_word) put_word(mem_addr, mem_wdata);
                    else mem[mem_addr] = mem_wdata[7:0];
                end else if (mem_word) begin
                    mem_rdata = {rd8(mem_addr + 3), rd8(mem_addr + 2), rd8(mem_addr + 1), rd8(mem_addr)};
                end else begin
                    mem_rdata = {24'h0, rd8(mem_addr)};
                end
                mem_port32 = (kind != 2);
                mem_port8  = (kind == 3);
                if (kind == 1) mem_berr = 1'b1; else mem_ack = 1'b1;
                op_idx++;
            end
        end
    end

    // SCSI-side responder
    initial begin
        forever begin
            @(negedge clk);
            if (scsi_ack) begin
                scsi_ack = 1'b0;
            end else if (scsi_req) begin
                int nb;
                nb = scsi_word ? 4 : 1;
                scsi_rdata = 32'h0;
                for (int b = 0; b < nb; b++) begin
                    sink_q.push_back(scsi_wdata[8*b +: 8]);
                    if (src_q.size() > 0) scsi_rdata[8*b +: 8] = src_q.pop_front();
                end
                scsi_ack = 1'b1;
            end
        end
    end

    task automatic run(string tag, bit tm, bit dr, int unsigned da, int unsigned dc,
                       int unsigned tb, int ne, int ea, int ek, bit prog, int poke);
        int unsigned total;
        int t;
        int k;
        mem.delete(); sink_q.delete(); src_q.delete(); src_exp.delete();
        op_idx = 0; err_at = ea; err_kind = ek;
        for (int i = 0; i < ne; i++) begin
            put_word(tb + 8*i, e_addr[i]);
            put_word(tb + 8*i + 4, {e_last[i], 7'h0, e_cnt[i][23:0]});
        end
        build(tm, dr, da, dc, tb, ne);
        total = 0;
        foreach (seg_c[i]) total += seg_c[i];
        for (int unsigned i = 0; i < total; i++) begin
            src_q.push_back(8'(i * 13 + 8'h5a));
            src_exp.push_back(8'(i * 13 + 8'h5a));
        end
        if (prog) begin
            wr(2'd1, da); wr(2'd2, dc); wr(2'd3, tb);
        end
        wr(2'd0, {29'h0, dr, tm, 1'b1});
        if (poke == 1) begin
            repeat (6) @(negedge clk);
            wr(2'd1, 32'h900);
            wr(2'd0, 32'h7);
            chk("R11", {tag, " mode/dir bits after write while busy"},
                32'(csr_o[2:1]), 32'({dr, tm}));
        end
        t = 0;
        while (!csr_o[7] && t < 3000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
        chk("R3 R12", {tag, " control/status image"}, 32'(csr_o), 32'(exp_hi | {5'h0, dr, tm, 1'b1}));
        chk("R3", {tag, " model cycles left over"}, exp_q.size(), 0);
        if (exp_hi == 8'h80) begin
            k = 0;
            foreach (seg_a[i]) begin
                for (int unsigned j = 0; j < seg_c[i]; j++) begin
                    if (dr)
                        chk("R4", {tag, " byte sent to SCSI"},
                            (k < sink_q.size()) ? 32'(sink_q[k]) : 32'hdead, 32'(rd8(seg_a[i] + j)));
                    else
                        chk("R4", {tag, " byte stored in memory"},
                            mem.exists(seg_a[i] + j) ? 32'(mem[seg_a[i] + j]) : 32'hdead,
                            32'(src_exp[k]));
                    k++;
                end
            end
            if (dr) chk("R4", {tag, " SCSI byte count"}, sink_q.size(), total);
        end
        if (poke == 2) begin
            wr(2'd0, {29'h0, dr, tm, 1'b1});
            repeat (10) @(negedge clk);
            chk("R10", {tag, " status after repeated enable"}, 32'(csr_o),
                32'(exp_hi | {5'h0, dr, tm, 1'b1}));
        end
        wr(2'd0, 32'h0);
        chk("R2", {tag, " image after disable"}, 32'(csr_o), 32'h0);
        repeat (2) @(negedge clk);
        chk("R2", {tag, " no request while disabled"}, 32'({mem_req, scsi_req}), 32'h0);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "image in reset", 32'(csr_o), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "image after reset", 32'(csr_o), 32'h0);
        chk("R1", "requests after reset", 32'({mem_req, scsi_req}), 32'h0);

        run("direct-in", 0, 0, 32'h100, 11, 0, 0, -1, 0, 1, 0);
        run("direct-out", 0, 1, 32'h203, 6, 0, 0, -1, 0, 1, 0);
        run("direct-zero", 0, 0, 32'h180, 0, 0, 0, -1, 0, 1, 0);

        e_addr[0] = 32'h400; e_cnt[0] = 5; e_last[0] = 0;
        e_addr[1] = 32'h500; e_cnt[1] = 0; e_last[1] = 0;
        e_addr[2] = 32'h600; e_cnt[2] = 8; e_last[2] = 1;
        run("table-in", 1, 0, 0, 0, 32'h1000, 3, -1, 0, 1, 0);

        e_addr[0] = 32'h700; e_cnt[0] = 3; e_last[0] = 0;
        e_addr[1] = 32'h800; e_cnt[1] = 9; e_last[1] = 1;
        run("table-out", 1, 1, 0, 0, 32'h1100, 2, -1, 0, 1, 0);

        e_addr[0] = 32'h400; e_cnt[0] = 4; e_last[0] = 0;
        e_addr[1] = 32'h500; e_cnt[1] = 4; e_last[1] = 1;
        run("R6 fetch-berr", 1, 1, 0, 0, 32'h1200, 2, 3, 1, 1, 0);
        run("R8 fetch-narrow", 1, 0, 0, 0, 32'h1200, 2, 0, 2, 1, 0);
        run("R7 data-berr", 0, 0, 32'h140, 8, 0, 0, 1, 1, 1, 0);
        run("R9 data-8bit", 0, 1, 32'h160, 8, 0, 0, 0, 3, 1, 0);

        run("R11 busy-poke", 0, 0, 32'h300, 40, 0, 0, -1, 0, 1, 1);
        run("R11 rerun-kept-addr", 0, 0, 32'h300, 40, 0, 0, -1, 0, 0, 0);
        run("R10 sticky", 0, 1, 32'h40, 5, 0, 0, -1, 0, 1, 2);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule